// File: doc/BRIEF.md
# Serial port status flag unit

This block keeps the status word of a serial port that runs either clock-synchronous or as a UART. The bit-level shift engines sit elsewhere. They report to this block through single-cycle strobes:
- the transmit side reports when its buffer is loaded, when the buffer moves into the shift register, when the first data bit starts and when the last data bit ends;
- the receive side reports when a character is complete, along with that character's data, its parity sample and its stop-bit sample.

From these strobes the block keeps the transmit-buffer-empty, receive-buffer-full and transmit-complete indications. It holds the received character and raises sticky overrun, parity, framing and summary error flags. Each error flag has its own rules for when it is set and what clears it.

Software reaches the block through a small register port with two addresses. Address 0 is the status word. Address 1 is the receive buffer. A read of the receive buffer frees it. A write to the status word clears the error flags, whatever value is written. Turning the whole port off clears only the overrun flag. Turning the receiver off clears every error flag.

Top module: `ser_status_unit`

## Requirements
- R1: After reset the status word reads 0x05 (bit 0 transmit-buffer-empty = 1, bit 2 transmit-complete = 1, all other bits 0), and the receive buffer (address 1) reads 0.
- R2: Status bit 0 goes to 0 on a `tx_load` strobe and to 1 on a `tx_xfer` strobe. If both strobes come in the same cycle, `tx_load` wins.
- R3: Status bit 2 goes to 0 on `tx_first` and to 1 on `tx_last`. If both strobes come in the same cycle, `tx_last` wins.
- R4: A character arrives when `rx_done` is high while the port and the receiver are both enabled. If the buffer is empty, the character is captured and status bit 1 becomes 1. A read with `reg_rd_en` at address 1 returns the character zero-extended and clears bit 1. If a read and an arrival happen in the same cycle, the read returns the old character, the new one is captured, bit 1 stays 1 and no overrun is flagged.
- R5: If a character arrives while bit 1 is 1 and no read happens in that cycle, the overrun flag (bit 3) is set. The buffered character is kept and the new one is discarded. The discarded character's parity and stop samples are not checked.
- R6: The parity error flag (bit 4) is set by a captured character only in UART mode with parity enabled. The check uses the XOR of the data bits, the parity sample and `cfg_par_odd`. Even parity (`cfg_par_odd`=0) fails when the XOR of the data bits and the parity sample is 1. Odd parity fails when that XOR is 0.
- R7: The framing error flag (bit 5) is set by a captured character in UART mode whose stop sample is 0. In synchronous mode it is never set.
- R8: The summary flag (bit 6) is set in any cycle that sets an overrun, parity or framing error.
- R9: A write strobe at address 0 clears bits 3 to 6 whatever the data value is. It leaves bits 0 to 2 unchanged.
- R10: While `cfg_ser_en` is 0, the overrun flag is cleared. The parity, framing and summary flags are kept.
- R11: While `cfg_rx_en` is 0, bits 3 to 6 are cleared. While either enable is 0, `rx_done` is ignored: no capture happens and bit 1 does not change.
- R12: If an error-setting event and a clearing write happen in the same cycle, the flags named by the event end up set.
- R13: Status bit 7 always reads 0. Reading the status word changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ser_en | input | 1 | Serial port enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_uart | input | 1 | 1 = UART mode, 0 = clock-synchronous mode |
| cfg_par_en | input | 1 | Parity checking enable (UART only) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_load | input | 1 | Transmit buffer written |
| tx_xfer | input | 1 | Transmit buffer moved into the shift register |
| tx_first | input | 1 | First data bit starts shifting |
| tx_last | input | 1 | Last data bit finished shifting |
| rx_done | input | 1 | Receive shift register holds a complete character |
| rx_data | input | DATA_W | Received character |
| rx_par_bit | input | 1 | Sampled parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| reg_addr | input | 1 | 0 = status word, 1 = receive buffer |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wdata | input | REG_W | Write data (no effect) |
| reg_rdata | output | REG_W | Read data for the selected address |

## Verification
The hardest cases to reach from the ports are the ones where two events land in the same clock edge:
- a buffer read together with an arrival, which must not flag an overrun;
- a clearing write together with an error-setting arrival, where the set must win.

The bench drives these by raising both strobes on the same falling edge, so that a single rising edge latches them together. It also checks the state that follows a partial clear. First it builds up overrun together with a framing error. Then it turns off only the port enable, and then only the receiver enable, and each time it shows which flags remain. An exhaustive sweep covers every 8-bit character against both parity senses and both parity samples.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;

   // Status word bit positions (software decodes these)
   localparam int SB_TXE = 0;
   localparam int SB_RXF = 1;
   localparam int SB_TXC = 2;
   localparam int SB_OVR = 3;
   localparam int SB_PAR = 4;
   localparam int SB_FRM = 5;
   localparam int SB_SUM = 6;

   // Error flag slice indices, in status-bit order starting at SB_OVR
   localparam int EF_OVR = 0;
   localparam int EF_PAR = 1;
   localparam int EF_FRM = 2;
   localparam int EF_SUM = 3;
   localparam int EF_NUM = 4;

   // Which error flags are also cleared when the port is switched off
   localparam logic [EF_NUM-1:0] EF_SER_OFF_MASK = 4'b0001;

   // Register port addresses
   localparam logic ADDR_STATUS = 1'b0;
   localparam logic ADDR_RXBUF  = 1'b1;

   typedef struct packed {
      logic frm;
      logic par;
      logic ovr;
   } rx_err_t;

endpackage

// File: rtl/ser_tx_flags.sv
module ser_tx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_load,
   input  logic tx_xfer,
   input  logic tx_first,
   input  logic tx_last,
   output logic txe_q,
   output logic txc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe_q <= 1'b1;
      end else if (tx_load) begin
         txe_q <= 1'b0;
      end else if (tx_xfer) begin
         txe_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txc_q <= 1'b1;
      end else if (tx_last) begin
         txc_q <= 1'b1;
      end else if (tx_first) begin
         txc_q <= 1'b0;
      end
   end

   AST_TXE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !txe_q);                                   // R2
   AST_TXE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_xfer && !tx_load) |=> txe_q);                      // R2
   AST_TXC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |=> txc_q);                                    // R3
   AST_TXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_first && !tx_last) |=> !txc_q);                    // R3

endmodule

// File: rtl/ser_rx_capture.sv
module ser_rx_capture
   import ser_status_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_ok,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_bit,
   input  logic              rx_stop_bit,
   input  logic              cfg_uart,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              buf_rd,
   output logic [DATA_W-1:0] buf_q,
   output logic              full_q,
   output rx_err_t           err_set
);

   logic arrive;
   logic accept;
   logic overrun;
   logic par_bad;

   assign arrive  = rx_done && rx_ok;
   assign accept  = arrive && (!full_q || buf_rd);
   assign overrun = arrive && full_q && !buf_rd;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_bad = cfg_uart && cfg_par_en &&
                          ((^rx_data) ^ rx_par_bit ^ cfg_par_odd);
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = rx_par_bit ^ cfg_par_odd ^ cfg_par_en;
         assign par_bad    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (accept) begin
         full_q <= 1'b1;
      end else if (buf_rd) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (accept) begin
         buf_q <= rx_data;
      end
   end

   always_comb begin
      err_set     = '0;
      err_set.ovr = overrun;
      err_set.par = accept && par_bad;
      err_set.frm = accept && cfg_uart && !rx_stop_bit;
   end

   AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> $stable(buf_q));                           // R5
   AST_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> full_q);                                    // R4
   AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ok && !buf_rd) |=> $stable(full_q));              // R11

endmodule

// File: rtl/ser_err_flag.sv
module ser_err_flag #(
   parameter bit CLR_ON_SER_OFF = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr_wr,
   input  logic clr_rx,
   input  logic clr_ser,
   output logic q
);

   logic clr;

   generate
      if (CLR_ON_SER_OFF) begin : g_ser
         assign clr = clr_wr || clr_rx || clr_ser;
      end else begin : g_noser
         logic unused_ser;
         assign unused_ser = clr_ser;
         assign clr        = clr_wr || clr_rx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);                                            // R12
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !set) |=> !q);                              // R9

endmodule

// File: rtl/ser_status_unit.sv
module ser_status_unit
   import ser_status_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int REG_W      = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ser_en,
   input  logic              cfg_rx_en,
   input  logic              cfg_uart,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              tx_load,
   input  logic              tx_xfer,
   input  logic              tx_first,
   input  logic              tx_last,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_bit,
   input  logic              rx_stop_bit,
   input  logic              reg_addr,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata
);

   localparam int STAT_W = SB_SUM + 1;

   generate
      if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data_w
         $error("ser_status_unit: DATA_W must lie in 1..REG_W");
      end
      if (REG_W < STAT_W) begin : g_bad_reg_w
         $error("ser_status_unit: REG_W too narrow for the status word");
      end
   endgenerate

   logic              unused_wdata;
   logic              txe_q, txc_q, full_q;
   logic [DATA_W-1:0] buf_q;
   rx_err_t           err_set;
   logic [EF_NUM-1:0] ef_set, ef_q;
   logic              wr_status, rd_rxbuf;
   logic [REG_W-1:0]  status;

   assign unused_wdata = ^reg_wdata;
   assign wr_status    = reg_wr_en && (reg_addr == ADDR_STATUS);
   assign rd_rxbuf     = reg_rd_en && (reg_addr == ADDR_RXBUF);

   ser_tx_flags u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_load  (tx_load),
      .tx_xfer  (tx_xfer),
      .tx_first (tx_first),
      .tx_last  (tx_last),
      .txe_q    (txe_q),
      .txc_q    (txc_q)
   );

   ser_rx_capture #(
      .DATA_W     (DATA_W),
      .HAS_PARITY (HAS_PARITY)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_ok       (cfg_ser_en && cfg_rx_en),
      .rx_done     (rx_done),
      .rx_data     (rx_data),
      .rx_par_bit  (rx_par_bit),
      .rx_stop_bit (rx_stop_bit),
      .cfg_uart    (cfg_uart),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .buf_rd      (rd_rxbuf),
      .buf_q       (buf_q),
      .full_q      (full_q),
      .err_set     (err_set)
   );

   assign ef_set[EF_OVR] = err_set.ovr;
   assign ef_set[EF_PAR] = err_set.par;
   assign ef_set[EF_FRM] = err_set.frm;
   assign ef_set[EF_SUM] = err_set.ovr || err_set.par || err_set.frm;

   generate
      for (genvar i = 0; i < EF_NUM; i++) begin : g_ef
         ser_err_flag #(
            .CLR_ON_SER_OFF (EF_SER_OFF_MASK[i])
         ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set     (ef_set[i]),
            .clr_wr  (wr_status),
            .clr_rx  (!cfg_rx_en),
            .clr_ser (!cfg_ser_en),
            .q       (ef_q[i])
         );
      end
   endgenerate

   always_comb begin
      status         = '0;
      status[SB_TXE] = txe_q;
      status[SB_RXF] = full_q;
      status[SB_TXC] = txc_q;
      status[SB_OVR] = ef_q[EF_OVR];
      status[SB_PAR] = ef_q[EF_PAR];
      status[SB_FRM] = ef_q[EF_FRM];
      status[SB_SUM] = ef_q[EF_SUM];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_STATUS) begin
         reg_rdata = status;
      end else begin
         reg_rdata[DATA_W-1:0] = buf_q;
      end
   end

   AST_SER_OFF_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ser_en |=> !ef_q[EF_OVR]);                        // R10
   AST_RX_OFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rx_en |=> (ef_q == '0));                          // R11
   AST_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ef_q[EF_OVR]) || $rose(ef_q[EF_PAR]) || $rose(ef_q[EF_FRM]))
      |-> ef_q[EF_SUM]);                                     // R8
   AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_addr == ADDR_STATUS && !rx_done && !reg_wr_en &&
       cfg_ser_en && cfg_rx_en && !tx_load && !tx_xfer && !tx_first && !tx_last)
      |=> $stable(status));                                  // R13

endmodule

// File: tb/ser_status_unit_bench.sv
`timescale 1ns/1ps
module ser_status_unit_bench;

   localparam int DW = 8;
   localparam int RW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_ser_en = 1'b0, cfg_rx_en = 1'b0, cfg_uart = 1'b0;
   logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic tx_load = 1'b0, tx_xfer = 1'b0, tx_first = 1'b0, tx_last = 1'b0;
   logic rx_done = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic rx_par_bit = 1'b0, rx_stop_bit = 1'b1;
   logic reg_addr = 1'b0, reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ser_status_unit #(.DATA_W(DW), .REG_W(RW)) u_ser_status_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_ser_en(cfg_ser_en), .cfg_rx_en(cfg_rx_en), .cfg_uart(cfg_uart),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .tx_load(tx_load), .tx_xfer(tx_xfer), .tx_first(tx_first), .tx_last(tx_last),
      .rx_done(rx_done), .rx_data(rx_data), .rx_par_bit(rx_par_bit),
      .rx_stop_bit(rx_stop_bit),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [7:0] st(input bit txe, rxf, txc, ovr, par, frm, sum);
      return {1'b0, sum, frm, par, ovr, txc, rxf, txe};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd_status(output logic [7:0] v);
      reg_addr = 1'b0;
      #1 v = reg_rdata;
   endtask

   task automatic rd_buf(output logic [7:0] v);
      @(negedge clk);
      reg_addr = 1'b1; reg_rd_en = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0; reg_addr = 1'b0;
   endtask

   task automatic wr_status(input logic [7:0] d);
      @(negedge clk);
      reg_addr = 1'b0; reg_wr_en = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rx_char(input logic [7:0] d, input bit p, input bit stp);
      @(negedge clk);
      rx_done = 1'b1; rx_data = d; rx_par_bit = p; rx_stop_bit = stp;
      @(negedge clk);
      rx_done = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, w;
      repeat (3) @(negedge clk);
      rd_status(v);
      check("R1 status reset", v, 8'h05);
      reg_addr = 1'b1; #1 check("R1 rx buffer reset", reg_rdata, 8'h00); reg_addr = 1'b0;
      rst_n = 1'b1; cfg_ser_en = 1'b1; cfg_rx_en = 1'b1;

      // R2 / R3 transmit flags
      @(negedge clk); tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
      rd_status(v); check("R2 load clears empty", v, st(0,0,1,0,0,0,0));
      @(negedge clk); tx_load = 1'b1; tx_xfer = 1'b1; @(negedge clk); tx_load = 1'b0; tx_xfer = 1'b0;
      rd_status(v); check("R2 load wins over xfer", v, st(0,0,1,0,0,0,0));
      @(negedge clk); tx_xfer = 1'b1; @(negedge clk); tx_xfer = 1'b0;
      rd_status(v); check("R2 xfer sets empty", v, st(1,0,1,0,0,0,0));
      @(negedge clk); tx_first = 1'b1; @(negedge clk); tx_first = 1'b0;
      rd_status(v); check("R3 first bit clears complete", v, st(1,0,0,0,0,0,0));
      @(negedge clk); tx_first = 1'b1; tx_last = 1'b1; @(negedge clk); tx_first = 1'b0; tx_last = 1'b0;
      rd_status(v); check("R3 last wins over first", v, st(1,0,1,0,0,0,0));

      // R6 exhaustive parity sweep in UART mode, parity enabled
      cfg_uart = 1'b1; cfg_par_en = 1'b1;
      for (int odd = 0; odd < 2; odd++) begin
         cfg_par_odd = odd[0];
         for (int d = 0; d < 256; d++) begin
            for (int p = 0; p < 2; p++) begin
               bit e;
               e = (($countones(d[7:0]) + p) % 2) != odd;
               rx_char(d[7:0], p[0], 1'b1);
               rd_status(v);
               check("R6 parity flag", v, st(1,1,1,0,e,0,e));
               rd_buf(w);
               check("R4 buffer data", w, d[7:0]);
               rd_status(v);
               check("R4 read clears full", v, st(1,0,1,0,e,0,e));
               wr_status(8'hA5);
            end
         end
      end

      // R7 framing, parity off
      cfg_par_en = 1'b0;
      rx_char(8'h01, 1'b0, 1'b0);
      rd_status(v); check("R7 framing in UART, parity off", v, st(1,1,1,0,0,1,1));
      rd_buf(w); wr_status(8'h00);

      // R6/R7 synchronous mode never flags parity or framing
      cfg_uart = 1'b0; cfg_par_en = 1'b1;
      rx_char(8'h01, 1'b0, 1'b0);
      rd_status(v); check("R7 no framing/parity in sync", v, st(1,1,1,0,0,0,0));
      rd_buf(w);

      // R5 overrun keeps old character
      rx_char(8'h3C, 1'b0, 1'b1);
      rx_char(8'hC3, 1'b0, 1'b1);
      rd_status(v); check("R5 overrun + R8 summary", v, st(1,1,1,1,0,0,1));
      rd_buf(w); check("R5 old character kept", w, 8'h3C);

      // R9 write with all-ones data: only error bits cleared
      wr_status(8'hFF);
      rd_status(v); check("R9 write clears errors only", v, st(1,0,1,0,0,0,0));

      // R4 read in same cycle as arrival
      rx_char(8'h11, 1'b0, 1'b1);
      @(negedge clk);
      reg_addr = 1'b1; reg_rd_en = 1'b1; rx_done = 1'b1; rx_data = 8'h22;
      #1 w = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0; rx_done = 1'b0; reg_addr = 1'b0;
      check("R4 simultaneous read returns old", w, 8'h11);
      rd_status(v); check("R4 simultaneous read no overrun", v, st(1,1,1,0,0,0,0));
      rd_buf(w); check("R4 new character captured", w, 8'h22);

      // R10 port off clears overrun only
      cfg_uart = 1'b1; cfg_par_en = 1'b0;
      rx_char(8'h55, 1'b0, 1'b0);
      rx_char(8'h66, 1'b0, 1'b1);
      rd_status(v); check("R5 overrun with framing", v, st(1,1,1,1,0,1,1));
      @(negedge clk); cfg_ser_en = 1'b0;
      rx_char(8'h77, 1'b0, 1'b1);
      rd_status(v); check("R10 port off keeps frm/sum", v, st(1,1,1,0,0,1,1));
      cfg_ser_en = 1'b1;
      rd_buf(w); check("R11 arrival ignored while port off", w, 8'h55);

      // R11 receiver off clears all errors, arrival ignored
      rx_char(8'h80, 1'b0, 1'b0);
      rd_status(v); check("R7 framing before rx off", v, st(1,1,1,0,0,1,1));
      @(negedge clk); cfg_rx_en = 1'b0;
      rx_char(8'h99, 1'b0, 1'b0);
      rd_status(v); check("R11 rx off clears errors", v, st(1,1,1,0,0,0,0));
      cfg_rx_en = 1'b1;
      rd_buf(w); check("R11 arrival ignored while rx off", w, 8'h80);

      // R12 set wins over clearing write
      @(negedge clk);
      reg_addr = 1'b0; reg_wr_en = 1'b1; reg_wdata = 8'h00;
      rx_done = 1'b1; rx_data = 8'h42; rx_stop_bit = 1'b0;
      @(negedge clk);
      reg_wr_en = 1'b0; rx_done = 1'b0; rx_stop_bit = 1'b1;
      rd_status(v); check("R12 set wins over write", v, st(1,1,1,0,0,1,1));

      // R13 status reads are side-effect free, bit 7 is 0
      @(negedge clk); reg_addr = 1'b0; reg_rd_en = 1'b1;
      @(negedge clk); reg_rd_en = 1'b0;
      rd_status(v); check("R13 status read quiet", v, st(1,1,1,0,0,1,1));
      check("R13 bit 7 zero", {7'd0, v[7]}, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule